// File: doc/BRIEF.md
# CAN bit timing and synchronization unit

This unit turns a time-quantum tick and the synchronized receive line of a CAN node into bit-level timing. Each bit is built from a one-quantum synchronization segment followed by a propagation segment and two phase segments, each with its own configured length. The unit tells the frame logic where each bit begins and where the line is sampled, and it returns the sampled value.

While the bus is idle, a recessive-to-dominant transition is taken as the start of a frame: the bit time restarts at once, with the current quantum becoming the synchronization segment. Outside the idle state, recessive-to-dominant transitions that arrive away from the synchronization segment pull the bit phase toward the transmitter. An early edge (before the sample point) stretches the first phase segment, and a late edge (after it) cuts the second phase segment short. The correction is limited by a configured jump width and is applied at most once per bit. Frame decoding, stuffing and error handling belong to the surrounding controller.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted and after its release, until the first quantum tick, bit_start and sample_point are 0 and sampled_bit is 1 (recessive).
- R2: A configuration field of value f gives a segment of f+1 quanta; with no falling edges a bit lasts 1+P+T1+T2 ticks (P, T1, T2 the propagation, first and second phase lengths). bit_start is a one-clock pulse in the clock cycle after the tick that begins the synchronization quantum.
- R3: sample_point is a one-clock pulse in the cycle after the tick that begins the first quantum of the second phase segment. In that cycle sampled_bit takes the rx value seen at that tick, and sampled_bit changes at no other time.
- R4: When bus_idle is 1 and a falling edge is seen at a tick, that tick begins a synchronization quantum (bit_start follows) from any position in the bit, and no sample point is produced at that tick.
- R5: The line is looked at only on ticks: a falling edge means rx is 0 at a tick and was 1 at the previous tick. While bus_idle is 0 a falling edge never restarts the bit; it is handled as a resynchronization.
- R6: A rising edge (rx 0 at the previous tick, 1 at this one) changes neither the bit length nor the sample position.
- R7: A falling edge at the tick that begins the synchronization quantum makes no correction and does not use up the bit's one correction.
- R8: A falling edge at the tick that begins quantum k of the bit, with 1 <= k < 1+P+T1, adds min(k, SJW) quanta to the first phase segment, where SJW is the jump-width field plus 1.
- R9: A falling edge at a tick in the second phase segment, with r quanta left in the bit counting the current one, makes the current quantum the synchronization quantum if r <= SJW, and otherwise removes SJW quanta from the segment. An edge at the sample tick is treated this way, and the sample pulse still occurs.
- R10: Only one correction is made per bit; a later falling edge in the same bit, or any edge after a hard restart until the next regular bit start, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_tick | input | 1 | One-clock pulse at the start of each time quantum |
| rx | input | 1 | Synchronized receive line, 1 recessive, 0 dominant |
| bus_idle | input | 1 | High while the bus is idle; arms hard synchronization |
| cfg_prop_seg | input | SEG_W | Propagation segment length minus 1 |
| cfg_phase1 | input | SEG_W | First phase segment length minus 1 |
| cfg_phase2 | input | SEG_W | Second phase segment length minus 1 |
| cfg_sjw | input | SJW_W | Resynchronization jump width minus 1 |
| sample_point | output | 1 | One-clock pulse at the sample point |
| sampled_bit | output | 1 | Last sampled rx value |
| bit_start | output | 1 | One-clock pulse at each bit start |

## Verification
The bench uses the default widths, so segments range from 1 to 8 quanta and the jump width from 1 to 4. It runs three configurations: a middle one with every correction case placed by hand, an all-minimum one where the jump width exceeds the second phase segment, so every late edge snaps to a new bit, and an all-maximum one where corrections are clipped. Pseudo-random line activity, bus-idle changes and uneven tick spacing then let the behavioural model check edges at every quantum position.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

endpackage

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (tick) begin
            prev_d = rx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    // recessive (1) at the previous quantum, dominant (0) now
    assign fall = tick & prev_q & ~rx;
endmodule

// File: rtl/can_bt_step.sv
module can_bt_step
    import can_bt_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  seg_e             seg_q,
    input  logic [POS_W-1:0] cnt_q,
    input  logic [POS_W-1:0] ext_q,
    input  logic             done_q,
    input  logic [POS_W-1:0] prop_len,
    input  logic [POS_W-1:0] ph1_len,
    input  logic [POS_W-1:0] ph2_len,
    output seg_e             adv_seg,
    output logic [POS_W-1:0] adv_cnt,
    output logic [POS_W-1:0] adv_ext,
    output logic             adv_done
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] ph1_total;

    always_comb begin
        ph1_total = ph1_len + ext_q;
        adv_seg   = seg_q;
        adv_cnt   = cnt_q + ONE;
        adv_ext   = ext_q;
        adv_done  = done_q;
        unique case (seg_q)
            SEG_SYNC: begin
                adv_seg = SEG_PROP;
                adv_cnt = '0;
            end
            SEG_PROP: begin
                if (cnt_q == prop_len - ONE) begin
                    adv_seg = SEG_PH1;
                    adv_cnt = '0;
                end
            end
            SEG_PH1: begin
                if (cnt_q == ph1_total - ONE) begin
                    adv_seg = SEG_PH2;
                    adv_cnt = '0;
                end
            end
            SEG_PH2: begin
                if (cnt_q == ph2_len - ONE) begin
                    adv_seg  = SEG_SYNC;
                    adv_cnt  = '0;
                    adv_ext  = '0;
                    adv_done = 1'b0;
                end
            end
            default: begin
                adv_seg = SEG_SYNC;
                adv_cnt = '0;
            end
        endcase
    end
endmodule

// File: rtl/can_bt_phase.sv
module can_bt_phase
    import can_bt_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  seg_e             adv_seg,
    input  logic [POS_W-1:0] adv_cnt,
    input  logic [POS_W-1:0] prop_len,
    input  logic [POS_W-1:0] ph2_len,
    input  logic [POS_W-1:0] sjw_len,
    output logic [POS_W-1:0] grow_amt,
    output logic             shrink_to_sync,
    output logic [POS_W-1:0] shrink_cnt
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] early_err;
    logic [POS_W-1:0] late_left;

    always_comb begin
        // quanta elapsed since the synchronization quantum
        if (adv_seg == SEG_PROP) begin
            early_err = adv_cnt + ONE;
        end else begin
            early_err = prop_len + adv_cnt + ONE;
        end
        grow_amt = (early_err < sjw_len) ? early_err : sjw_len;

        // quanta left in the bit, counting the current one
        late_left      = ph2_len - adv_cnt;
        shrink_to_sync = (late_left <= sjw_len);
        shrink_cnt     = adv_cnt + sjw_len;
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx,
    input  logic             bus_idle,
    input  logic [SEG_W-1:0] cfg_prop_seg,
    input  logic [SEG_W-1:0] cfg_phase1,
    input  logic [SEG_W-1:0] cfg_phase2,
    input  logic [SJW_W-1:0] cfg_sjw,
    output logic             sample_point,
    output logic             sampled_bit,
    output logic             bit_start
);
    localparam int POS_W = ((SEG_W > SJW_W) ? SEG_W : SJW_W) + 3;
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    typedef struct packed {
        seg_e             seg;
        logic [POS_W-1:0] cnt;
        logic [POS_W-1:0] ext;
        logic             done;
        logic             sp;
        logic             sb;
        logic             bs;
    } bt_state_t;

    bt_state_t st_d, st_q;

    logic [POS_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
    seg_e             adv_seg;
    logic [POS_W-1:0] adv_cnt, adv_ext;
    logic             adv_done;
    logic [POS_W-1:0] grow_amt, shrink_cnt;
    logic             shrink_to_sync;
    logic             fall;

    assign prop_len = POS_W'(cfg_prop_seg) + ONE;
    assign ph1_len  = POS_W'(cfg_phase1) + ONE;
    assign ph2_len  = POS_W'(cfg_phase2) + ONE;
    assign sjw_len  = POS_W'(cfg_sjw) + ONE;

    can_bt_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tq_tick),
        .rx    (rx),
        .fall  (fall)
    );

    can_bt_step #(.POS_W(POS_W)) u_step (
        .seg_q    (st_q.seg),
        .cnt_q    (st_q.cnt),
        .ext_q    (st_q.ext),
        .done_q   (st_q.done),
        .prop_len (prop_len),
        .ph1_len  (ph1_len),
        .ph2_len  (ph2_len),
        .adv_seg  (adv_seg),
        .adv_cnt  (adv_cnt),
        .adv_ext  (adv_ext),
        .adv_done (adv_done)
    );

    can_bt_phase #(.POS_W(POS_W)) u_phase (
        .adv_seg        (adv_seg),
        .adv_cnt        (adv_cnt),
        .prop_len       (prop_len),
        .ph2_len        (ph2_len),
        .sjw_len        (sjw_len),
        .grow_amt       (grow_amt),
        .shrink_to_sync (shrink_to_sync),
        .shrink_cnt     (shrink_cnt)
    );

    always_comb begin
        logic hard;
        hard    = 1'b0;
        st_d    = st_q;
        st_d.sp = 1'b0;
        st_d.bs = 1'b0;
        if (tq_tick) begin
            st_d.seg  = adv_seg;
            st_d.cnt  = adv_cnt;
            st_d.ext  = adv_ext;
            st_d.done = adv_done;
            if (fall && bus_idle) begin
                // start of frame: restart the bit here
                hard      = 1'b1;
                st_d.seg  = SEG_SYNC;
                st_d.cnt  = '0;
                st_d.ext  = '0;
                st_d.done = 1'b1;
            end else if (fall && !adv_done) begin
                unique case (adv_seg)
                    SEG_PROP, SEG_PH1: begin
                        st_d.ext  = grow_amt;
                        st_d.done = 1'b1;
                    end
                    SEG_PH2: begin
                        st_d.done = 1'b1;
                        if (shrink_to_sync) begin
                            st_d.seg = SEG_SYNC;
                            st_d.cnt = '0;
                            st_d.ext = '0;
                        end else begin
                            st_d.cnt = shrink_cnt;
                        end
                    end
                    default: begin
                    end
                endcase
            end
            st_d.sp = !hard && (adv_seg == SEG_PH2) && (adv_cnt == '0);
            if (st_d.sp) begin
                st_d.sb = rx;
            end
            st_d.bs = (st_d.seg == SEG_SYNC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seg  <= SEG_SYNC;
            st_q.cnt  <= '0;
            st_q.ext  <= '0;
            st_q.done <= 1'b0;
            st_q.sp   <= 1'b0;
            st_q.sb   <= 1'b1;
            st_q.bs   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_point = st_q.sp;
    assign sampled_bit  = st_q.sb;
    assign bit_start    = st_q.bs;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tq_tick,
    input logic             rx,
    input logic             bus_idle,
    input logic [SEG_W-1:0] cfg_prop_seg,
    input logic [SEG_W-1:0] cfg_phase1,
    input logic [SEG_W-1:0] cfg_phase2,
    input logic [SJW_W-1:0] cfg_sjw,
    input logic             sample_point,
    input logic             sampled_bit,
    input logic             bit_start
);
    localparam int LW = ((SEG_W > SJW_W) ? SEG_W : SJW_W) + 4;

    logic [LW-1:0] max_len;
    logic [LW-1:0] tick_cnt;
    logic          tick_rx_q;
    logic          sampled_seen;

    assign max_len = LW'(cfg_prop_seg) + LW'(cfg_phase1) + LW'(cfg_phase2)
                   + LW'(cfg_sjw) + LW'(5);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt     <= '0;
            tick_rx_q    <= 1'b1;
            sampled_seen <= 1'b0;
        end else begin
            if (tq_tick) begin
                tick_rx_q <= rx;
            end
            if (bit_start) begin
                tick_cnt <= tq_tick ? LW'(1) : '0;
            end else if (tq_tick && (tick_cnt != '1)) begin
                tick_cnt <= tick_cnt + LW'(1);
            end
            if (bit_start) begin
                sampled_seen <= 1'b0;
            end else if (sample_point) begin
                sampled_seen <= 1'b1;
            end
        end
    end

    // R2: a bit start follows a quantum tick
    p_bit_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> $past(tq_tick));

    // R3: a sample strobe follows a quantum tick
    p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_point |-> $past(tq_tick));

    // R3: the sampled value only moves with the sample strobe
    p_sampled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sampled_bit != $past(sampled_bit)) |-> sample_point);

    // R4: idle bus plus falling edge restarts the bit
    p_hard_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && bus_idle && !rx && tick_rx_q) |=> bit_start);

    // R10: one sample per bit
    p_one_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_point |-> !sampled_seen);

    // R8: lengthening never exceeds the jump width
    p_max_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> (tick_cnt <= max_len));
endmodule

bind can_bit_timer can_bit_timer_chk #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tq_tick      (tq_tick),
    .rx           (rx),
    .bus_idle     (bus_idle),
    .cfg_prop_seg (cfg_prop_seg),
    .cfg_phase1   (cfg_phase1),
    .cfg_phase2   (cfg_phase2),
    .cfg_sjw      (cfg_sjw),
    .sample_point (sample_point),
    .sampled_bit  (sampled_bit),
    .bit_start    (bit_start)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
    localparam int SEG_W = 3;
    localparam int SJW_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tq_tick = 1'b0;
    logic             rx = 1'b1;
    logic             bus_idle = 1'b1;
    logic [SEG_W-1:0] cfg_prop_seg = '0;
    logic [SEG_W-1:0] cfg_phase1 = '0;
    logic [SEG_W-1:0] cfg_phase2 = '0;
    logic [SJW_W-1:0] cfg_sjw = '0;
    logic             sample_point, sampled_bit, bit_start;

    always #2 clk = ~clk;

    can_bit_timer #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_can_bit_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tq_tick      (tq_tick),
        .rx           (rx),
        .bus_idle     (bus_idle),
        .cfg_prop_seg (cfg_prop_seg),
        .cfg_phase1   (cfg_phase1),
        .cfg_phase2   (cfg_phase2),
        .cfg_sjw      (cfg_sjw),
        .sample_point (sample_point),
        .sampled_bit  (sampled_bit),
        .bit_start    (bit_start)
    );

    int    checks = 0;
    int    fails = 0;
    bit    fin = 1'b0;
    string cur_req = "R1";

    // configured lengths in quanta
    int cP = 1, cT1 = 1, cT2 = 1, cS = 1;

    // behavioural model: position in bit, phase-1 stretch, correction used
    int m_pos, m_ext;
    bit m_done, m_prev;
    bit e_sp = 1'b0, e_bs = 1'b0, e_sb = 1'b1;
    int since = 0, meas_len = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        int  a, l1, rem;
        bit  fe, hard, smp;
        if (!rst_n) begin
            m_pos = 0; m_ext = 0; m_done = 0; m_prev = 1;
            e_sp = 0; e_bs = 0; e_sb = 1;
            since = 0;
        end else begin
            if (bit_start) begin
                meas_len = since;
                since = 0;
            end
            e_sp = 0;
            e_bs = 0;
            if (tq_tick) begin
                since++;
                a = m_pos + 1;
                if (a >= 1 + cP + cT1 + m_ext + cT2) begin
                    a = 0; m_ext = 0; m_done = 0;
                end
                fe = m_prev && !rx;
                m_prev = rx;
                hard = 0;
                l1 = 1 + cP + cT1 + m_ext;
                smp = (a == l1);
                if (fe && bus_idle) begin
                    a = 0; m_ext = 0; m_done = 1; hard = 1;
                end else if (fe && !m_done && a != 0) begin
                    m_done = 1;
                    if (a < l1) begin
                        m_ext = (a < cS) ? a : cS;
                    end else begin
                        rem = l1 + cT2 - a;
                        if (rem <= cS) begin
                            a = 0; m_ext = 0;
                        end else begin
                            a = a + cS;
                        end
                    end
                end
                e_sp = smp && !hard;
                if (e_sp) e_sb = rx;
                e_bs = (a == 0);
                m_pos = a;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            checks++;
            if (bit_start !== e_bs || sample_point !== e_sp || sampled_bit !== e_sb) begin
                fails++;
                $display("FAIL %s: bit_start/sample_point/sampled_bit actual %b%b%b expected %b%b%b",
                         cur_req, bit_start, sample_point, sampled_bit, e_bs, e_sp, e_sb);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tq(input bit rxv, input int gap = 0);
        @(negedge clk);
        rx = rxv;
        tq_tick = 1'b1;
        @(negedge clk);
        tq_tick = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic run_to_start();
        for (int g = 0; g < 64; g++) begin
            tq(1'b1);
            if (bit_start) break;
        end
        settle();
    endtask

    // falling edge on the tick that begins quantum k of the bit
    task automatic edge_at(input int k);
        for (int g = 0; g < 64; g++) begin
            if ((k != 0 && m_pos + 1 == k) ||
                (k == 0 && m_pos == cP + cT1 + m_ext + cT2)) break;
            tq(1'b1);
        end
        tq(1'b0);
    endtask

    task automatic do_reset(input int fp, input int f1, input int f2, input int fs);
        @(negedge clk);
        rst_n = 1'b0;
        tq_tick = 1'b0;
        rx = 1'b1;
        bus_idle = 1'b1;
        cfg_prop_seg = SEG_W'(fp);
        cfg_phase1 = SEG_W'(f1);
        cfg_phase2 = SEG_W'(f2);
        cfg_sjw = SJW_W'(fs);
        cP = fp + 1; cT1 = f1 + 1; cT2 = f2 + 1; cS = fs + 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:5] == 3'd0) bus_idle = ~bus_idle;
            tq((lfsr[2:0] == 3'd0) ? ~rx : rx, int'(lfsr[9]));
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!fin) begin
            fin = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // P=2, T1=3, T2=3, SJW=2: nominal bit 9 quanta, sample at quantum 6
        do_reset(1, 2, 2, 1);
        cur_req = "R1";
        chk(bit_start == 0 && sample_point == 0, "R1 strobes", {bit_start, sample_point}, 0);
        chk(sampled_bit == 1, "R1 sampled_bit", sampled_bit, 1);

        cur_req = "R4";
        repeat (5) tq(1'b1);
        tq(1'b0);
        chk(bit_start == 1, "R4 restart on idle edge", bit_start, 1);

        cur_req = "R2";
        bus_idle = 1'b0;
        repeat (20) tq(1'b0);
        settle();
        chk(meas_len == 9, "R2 nominal length", meas_len, 9);
        chk(sampled_bit == 0, "R3 sampled dominant", sampled_bit, 0);

        cur_req = "R6";
        repeat (4) tq(1'b0);
        tq(1'b1);
        run_to_start();
        chk(meas_len == 9, "R6 rising edge ignored", meas_len, 9);
        run_to_start();
        chk(sampled_bit == 1, "R3 sampled recessive", sampled_bit, 1);

        cur_req = "R7";
        edge_at(0);
        run_to_start();
        chk(meas_len == 9, "R7 edge in sync", meas_len, 9);

        cur_req = "R8";
        edge_at(1);
        run_to_start();
        chk(meas_len == 10, "R8 early edge e=1", meas_len, 10);
        edge_at(5);
        run_to_start();
        chk(meas_len == 11, "R8 early edge clipped", meas_len, 11);

        cur_req = "R9";
        edge_at(7);
        settle();
        chk(meas_len == 7, "R9 late edge to sync", meas_len, 7);
        run_to_start();
        edge_at(6);
        run_to_start();
        chk(meas_len == 7, "R9 edge at sample tick", meas_len, 7);

        cur_req = "R10";
        edge_at(1);
        tq(1'b1);
        edge_at(3);
        run_to_start();
        chk(meas_len == 10, "R10 second edge ignored", meas_len, 10);

        cur_req = "R5";
        edge_at(4);
        run_to_start();
        chk(meas_len == 11, "R5 busy bus does not restart", meas_len, 11);
        bus_idle = 1'b1;
        cur_req = "R4";
        edge_at(4);
        settle();
        chk(meas_len == 4, "R4 restart mid-bit", meas_len, 4);
        bus_idle = 1'b0;
        random_run(300);

        // all segments 1 quantum, SJW 4
        do_reset(0, 0, 0, 3);
        cur_req = "R9";
        random_run(400);

        // all segments 8 quanta, SJW 4
        do_reset(7, 7, 7, 3);
        cur_req = "R8";
        random_run(500);

        repeat (4) @(negedge clk);
        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule